// File: doc/BRIEF.md
# Periodic Battery Test Scheduler

This block decides when the backup battery is load-tested and holds the result. While the main supply is good, it connects the battery to a test load for a fixed window once per long interval. A divided clock tick sets both durations. If the digitised battery-low flag is seen at any point in that window, the block latches a warning. The warning drives an open-drain line, which is modelled as a pull-low enable.

The warning stays latched through later intervals, and no periodic test is run while it is set. Every power-up forces a fresh test once the recovery-done indication arrives, whether or not the warning is set. A good result from that test clears the warning, and periodic testing then starts again.

A supply failure moves the block to its off state at once. Any window in progress is aborted and the load is released. The warning is left as it was.

The sequencer has four states:

- ST_OFF: the supply is bad.
- ST_WAIT_REC: the supply is good and the block is waiting for recovery.
- ST_LOAD: the load window is open.
- ST_IDLE: the interval count is running.

Its transitions are:

- power-up: ST_OFF to ST_WAIT_REC.
- recovered: ST_WAIT_REC to ST_LOAD.
- window end: ST_LOAD to ST_IDLE.
- interval end with no warning: ST_IDLE to ST_LOAD.
- interval end with the warning set: ST_IDLE to ST_IDLE, with the count restarted.
- supply loss: any state to ST_OFF.

Top module: `batt_test_sched`

## Requirements
- R1: During and right after reset, `load_en` is 0 and `warn_pull` is 0. The sequencer sits in its off state.
- R2: Each load window that is not aborted keeps `load_en` at 1 for exactly LOAD_TICKS*TICK_DIV consecutive clock cycles.
- R3: If `batt_low` is 1 in any cycle of a completed window, `warn_pull` is 1 from the first cycle after the window onward. If `batt_low` is 0 in every cycle of the window, `warn_pull` is 0 from that cycle.
- R4: While `warn_pull` is 1, the end of an interval starts no window. `load_en` stays 0 and the warning stays set.
- R5: After every power-up, a window starts in the cycle after `recov_done` is first seen high, regardless of the warning. A good result from that window clears the warning.
- R6: No window starts while `supply_ok` is low, or after a supply rise before `recov_done` is seen.
- R7: If `supply_ok` is low on a clock edge, `load_en` is 0 after that edge, and `warn_pull` keeps its value across it.
- R8: Consider a completed window with no warning and an uninterrupted supply. The next window starts exactly INTERVAL_TICKS*TICK_DIV cycles after that window's last cycle, because the interval count restarts at each test end and at each power-up.
- R9: `warn_pull` changes only on the clock edge that ends a load window. A warning never sets or clears at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Main supply within tolerance |
| recov_done | input | 1 | Recovery time after supply rise has elapsed |
| batt_low | input | 1 | Comparator: battery below trip level under load |
| load_en | output | 1 | Connect battery to test load |
| warn_pull | output | 1 | Pull-low enable for the open-drain warning line |

## Verification
The assertions assume that `batt_low` is only meaningful while the load is connected. They also assume that `supply_ok` may drop at any cycle, so the window-length check applies only to windows whose last edge saw a good supply.

The assertions also assume that `recov_done` can be held high before a supply rise. In that case a power-up test follows the rise by two cycles.

The random phase drives all three inputs freely. Supply dropouts are kept rare, so that complete windows and full intervals still occur. Directed sequences cover the following cases:

- a delayed recovery
- a low flag in the middle of a window
- skipped intervals while the warning is set
- a bad and then a good power-up retest
- an abort during a window

// File: rtl/bts_pkg.sv
package bts_pkg;
    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_WAIT_REC = 2'd1,
        ST_LOAD     = 2'd2,
        ST_IDLE     = 2'd3
    } bts_state_e;
endpackage

// File: rtl/bts_tick_div.sv
module bts_tick_div #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_cnt
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt_q <= '0;
                end else if (run) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign tick = run && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/bts_phase_cnt.sv
module bts_phase_cnt #(
    parameter int unsigned PW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [PW-1:0] last,
    output logic          done
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = tick && (cnt_q == last);
endmodule

// File: rtl/bts_fsm.sv
module bts_fsm
    import bts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       recov_done,
    input  logic       batt_low,
    input  logic       phase_done,
    output bts_state_e state_q,
    output logic       phase_clr,
    output logic       load_en,
    output logic       warn_pull
);
    bts_state_e state_d;
    logic       saw_low_q;
    logic       warn_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:      state_d = ST_WAIT_REC;
            ST_WAIT_REC: if (recov_done) state_d = ST_LOAD;
            ST_LOAD:     if (phase_done) state_d = ST_IDLE;
            ST_IDLE:     if (phase_done) state_d = warn_q ? ST_IDLE : ST_LOAD;
            default:     state_d = ST_OFF;
        endcase
        if (!supply_ok) begin
            state_d = ST_OFF;
        end
    end

    assign phase_clr = (state_d != state_q) || phase_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saw_low_q <= 1'b0;
            warn_q    <= 1'b0;
        end else begin
            if (phase_clr) begin
                saw_low_q <= 1'b0;
            end else if (state_q == ST_LOAD && batt_low) begin
                saw_low_q <= 1'b1;
            end
            if (state_q == ST_LOAD && state_d == ST_IDLE) begin
                warn_q <= saw_low_q || batt_low;
            end
        end
    end

    always_comb begin
        load_en   = (state_q == ST_LOAD);
        warn_pull = warn_q;
    end
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched
    import bts_pkg::*;
#(
    parameter int unsigned TICK_DIV       = 32768,
    parameter int unsigned INTERVAL_TICKS = 86400,
    parameter int unsigned LOAD_TICKS     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic recov_done,
    input  logic batt_low,
    output logic load_en,
    output logic warn_pull
);
    localparam int unsigned MAXT = (INTERVAL_TICKS > LOAD_TICKS) ? INTERVAL_TICKS : LOAD_TICKS;
    localparam int unsigned PW   = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [PW-1:0] LOAD_LAST = PW'(LOAD_TICKS - 1);
    localparam logic [PW-1:0] INT_LAST  = PW'(INTERVAL_TICKS - 1);

    bts_state_e    state_q;
    logic          phase_clr;
    logic          phase_done;
    logic          run;
    logic          tick;
    logic [PW-1:0] last;

    assign run  = (state_q == ST_LOAD) || (state_q == ST_IDLE);
    assign last = (state_q == ST_LOAD) ? LOAD_LAST : INT_LAST;

    bts_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (phase_clr),
        .run  (run),
        .tick (tick)
    );

    bts_phase_cnt #(.PW(PW)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (phase_clr),
        .tick (tick),
        .last (last),
        .done (phase_done)
    );

    bts_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .recov_done(recov_done),
        .batt_low  (batt_low),
        .phase_done(phase_done),
        .state_q   (state_q),
        .phase_clr (phase_clr),
        .load_en   (load_en),
        .warn_pull (warn_pull)
    );
endmodule

// File: rtl/bts_checker.sv
module bts_checker
    import bts_pkg::*;
#(
    parameter int unsigned WIN = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       load_en,
    input logic       warn_pull,
    input bts_state_e state_q
);
    localparam int unsigned LW = $clog2(WIN + 2) + 1;
    logic [LW-1:0] win_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_len <= '0;
        end else begin
            win_len <= load_en ? win_len + 1'b1 : '0;
        end
    end

    assert_win_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(load_en) && $past(supply_ok)) |-> (win_len == LW'(WIN)));

    assert_win_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_len <= LW'(WIN));

    assert_warn_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_pull) |-> ($past(load_en) && !load_en));

    assert_no_test_warned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_en) && $past(warn_pull)) |-> ($past(state_q) == ST_WAIT_REC));

    assert_no_load_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !load_en);

    assert_warn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> $stable(warn_pull));

    assert_clear_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn_pull) |-> ($past(load_en) && !load_en));
endmodule

bind batt_test_sched bts_checker #(.WIN(LOAD_TICKS * TICK_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .load_en  (load_en),
    .warn_pull(warn_pull),
    .state_q  (state_q)
);

// File: tb/tb_batt_test_sched.sv
`timescale 1ns/1ps
module tb_batt_test_sched;
    localparam int D = 4;
    localparam int L = 2;
    localparam int I = 6;
    localparam int WIN = L * D;
    localparam int INT = I * D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic recov_done = 1'b0;
    logic batt_low = 1'b0;
    logic load_en;
    logic warn_pull;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    batt_test_sched #(.TICK_DIV(D), .INTERVAL_TICKS(I), .LOAD_TICKS(L)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .recov_done(recov_done),
        .batt_low(batt_low), .load_en(load_en), .warn_pull(warn_pull)
    );

    // Reference model: 0 off, 1 waiting recovery, 2 load window, 3 interval
    int m_mode = 0;
    int m_cnt = 0;
    bit m_acc = 0;
    bit m_warn = 0;

    function automatic bit exp_load(int mode);
        return mode == 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 0; m_cnt <= 0; m_acc <= 0; m_warn <= 0;
        end else if (!supply_ok) begin
            m_mode <= 0; m_cnt <= 0;
        end else begin
            case (m_mode)
                0: m_mode <= 1;
                1: if (recov_done) begin m_mode <= 2; m_cnt <= 0; m_acc <= 0; end
                2: begin
                    if (m_cnt == WIN - 1) begin
                        m_warn <= m_acc | batt_low;
                        m_mode <= 3; m_cnt <= 0;
                    end else begin
                        m_acc <= m_acc | batt_low;
                        m_cnt <= m_cnt + 1;
                    end
                end
                default: begin
                    if (m_cnt == INT - 1) begin
                        m_cnt <= 0;
                        if (!m_warn) begin m_mode <= 2; m_acc <= 0; end
                    end else begin
                        m_cnt <= m_cnt + 1;
                    end
                end
            endcase
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(load_en == exp_load(m_mode), {cur_tag, " load_en"}, load_en, exp_load(m_mode));
            chk(warn_pull == m_warn, {cur_tag, " warn_pull"}, warn_pull, m_warn);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_load(bit v);
        while (load_en != v) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        chk(load_en == 0, "R1 reset load", load_en, 0);
        chk(warn_pull == 0, "R1 reset warn", warn_pull, 0);
        rst_n = 1'b1;
        cyc(4);
        chk(load_en == 0, "R6 supply low", load_en, 0);

        // R6: supply up, recovery delayed
        cur_tag = "R6";
        supply_ok = 1'b1;
        cyc(10);
        chk(load_en == 0, "R6 before recovery", load_en, 0);

        // R5/R2: power-up test with a good battery
        cur_tag = "R2";
        recov_done = 1'b1;
        cyc(1);
        cyc(1);
        chk(load_en == 1, "R5 power-up test starts", load_en, 1);
        wait_load(1'b0);
        chk(warn_pull == 0, "R3 good battery", warn_pull, 0);

        // R8: next periodic test after a full interval
        cur_tag = "R8";
        cyc(INT - 1);
        chk(load_en == 0, "R8 before interval end", load_en, 0);
        cyc(1);
        chk(load_en == 1, "R8 periodic start", load_en, 1);

        // R3: low flag mid-window
        cur_tag = "R3";
        cyc(3);
        batt_low = 1'b1;
        cyc(1);
        batt_low = 1'b0;
        wait_load(1'b0);
        chk(warn_pull == 1, "R3 warn latched", warn_pull, 1);

        // R4: skipped intervals while warned
        cur_tag = "R4";
        begin
            int seen = 0;
            for (int k = 0; k < 3 * INT; k++) begin
                cyc(1);
                if (load_en) seen++;
            end
            chk(seen == 0, "R4 no test while warned", seen, 0);
            chk(warn_pull == 1, "R4 warn held", warn_pull, 1);
        end

        // R5: power-up retest, bad battery keeps warn, good clears it
        cur_tag = "R5";
        supply_ok = 1'b0;
        cyc(3);
        chk(warn_pull == 1, "R7 warn kept off", warn_pull, 1);
        supply_ok = 1'b1;
        batt_low = 1'b1;
        cyc(3);
        chk(load_en == 1, "R5 retest while warned", load_en, 1);
        wait_load(1'b0);
        batt_low = 1'b0;
        chk(warn_pull == 1, "R5 bad retest", warn_pull, 1);
        supply_ok = 1'b0;
        cyc(2);
        supply_ok = 1'b1;
        cyc(3);
        wait_load(1'b0);
        chk(warn_pull == 0, "R5 good retest clears", warn_pull, 0);

        // R7: abort a window with the low flag up
        cur_tag = "R7";
        wait_load(1'b1);
        cyc(2);
        batt_low = 1'b1;
        cyc(1);
        supply_ok = 1'b0;
        cyc(1);
        chk(load_en == 0, "R7 load released", load_en, 0);
        chk(warn_pull == 0, "R7 warn unchanged", warn_pull, 0);
        batt_low = 1'b0;
        supply_ok = 1'b1;

        // R9: constrained random mix
        cur_tag = "R9";
        for (int k = 0; k < 6000; k++) begin
            supply_ok  = ($urandom % 200) != 0;
            recov_done = ($urandom % 4) != 0;
            batt_low   = ($urandom % 40) == 0;
            cyc(1);
        end
        finish_run();
    end
endmodule